// File: doc/BRIEF.md
# SDRAM Single-Burst Access Sequencer

This block turns one user request into one complete burst on an SDRAM that has already been powered up, had its mode set and is being refreshed by other logic. A request carries a direction, a bank, a row and a starting column. The block opens the row with an activate command and waits the row-to-column delay. It then issues one read or write command with auto-precharge disabled. For a write it streams the burst of 16-bit words, with per-byte masks, onto the data bus. For a read it captures the words that the device returns after the CAS latency.

The row is left open when the burst ends, and the block only issues idle commands until the next request. A grant input from the refresh and initialization logic must be high before the block accepts a request. Each data word is tagged with the column it belongs to. On a write, a pull strobe asks the user for the next word one cycle before that word goes out, so all device pins come straight from registers.

Top module: `sdram_burst_seq`

## Requirements
- R1: `req_ready` is high only while `grant` is high and no access is in progress. A request raised while `grant` is low starts nothing: commands stay NOP and `busy` stays low.
- R2: Commands are encoded on {cs_n, ras_n, cas_n, we_n} as NOP 0111, ACTIVE 0011, READ 0101 and WRITE 0100. ACTIVE appears in the cycle after the clock edge that accepts a request, and carries the request bank on `sd_ba` and the row on `sd_addr`.
- R3: READ or WRITE appears exactly TRCD cycles after ACTIVE. It carries the bank, the start column on `sd_addr[8:0]` and zeros on every other address bit. The zero on bit 10 means no auto-precharge.
- R4: On a write, word k of the burst (k = 0..BURST_LEN-1) is on `dq_out` with `dq_oe` high in the cycle that is k cycles after the WRITE command. `wr_take` is high one cycle before each word, and the word is taken from `wr_data` at the clock edge ending that cycle. `dq_oe` is low in every other cycle.
- R5: During write data cycles, `sd_dqm` holds the `wr_mask` taken with that word. Bit 1 masks the upper byte and bit 0 the lower byte, and 1 means masked. Outside write data cycles `sd_dqm` is 00.
- R6: On a read, the value on `dq_in` in the cycle that is CAS_LAT+k cycles after the READ command appears on `rd_data` in the next cycle with `rd_valid` high. This gives BURST_LEN consecutive valid cycles.
- R7: The column tag of word k (`wr_col` while `wr_take` is high, `rd_col` while `rd_valid` is high) keeps the start column's bits above log2(BURST_LEN). Its low log2(BURST_LEN) bits equal (start + k) mod BURST_LEN.
- R8: `busy` is high from the ACTIVE cycle onward. A write drops it TRCD+BURST_LEN cycles after ACTIVE. A read drops it TRCD+CAS_LAT+BURST_LEN cycles after ACTIVE, which is the cycle of the last `rd_valid`.
- R9: After the burst the block never issues a precharge. Only NOP is issued until a new request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with the device |
| rst_n | input | 1 | Active-low synchronous reset |
| grant | input | 1 | Permission to start an access |
| req_valid | input | 1 | Request strobe |
| req_ready | output | 1 | Request accepted at the edge when both are high |
| req_write | input | 1 | 1 = write burst, 0 = read burst |
| req_bank | input | 2 | Target bank |
| req_row | input | 12 | Row to open |
| req_col | input | 9 | Start column |
| wr_take | output | 1 | Present the next write word in this cycle |
| wr_col | output | 9 | Column of the word being taken |
| wr_data | input | 16 | Write word |
| wr_mask | input | 2 | Byte mask of the write word, 1 = masked |
| rd_valid | output | 1 | Read word valid |
| rd_data | output | 16 | Read word |
| rd_col | output | 9 | Column of the read word |
| busy | output | 1 | Access in progress |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank address |
| sd_addr | output | 12 | Multiplexed row/column address |
| sd_dqm | output | 2 | Byte masks {upper, lower} |
| dq_oe | output | 1 | Data bus output enable |
| dq_out | output | 16 | Data driven onto the bus |
| dq_in | input | 16 | Data sampled from the bus |

## Verification
The assertions check the properties that hold cycle by cycle at the pins on every cycle:
- `req_ready` is never high without `grant`.
- Every ACTIVE follows an accepted request.
- READ and WRITE sit exactly TRCD cycles after ACTIVE, with address bit 10 low.
- `dq_oe` and non-zero masks occur only inside an access.
- Each captured read word equals the bus value one cycle earlier.
- No precharge command ever appears.

Only the bench scenarios can show the rest:
- The data order and masks of each write word.
- The column tags at every alignment, wrapping inside the burst.
- The exact cycle at which `busy` falls for each direction.
- Silence on the command pins after the burst.
- The behaviour with `grant` held low.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_NOP = 4'b0111,
    CMD_ACT = 4'b0011,
    CMD_RD  = 4'b0101,
    CMD_WR  = 4'b0100
  } sd_cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_GAP,
    ST_WBURST,
    ST_RWAIT
  } seq_st_e;

  // Column of word 'step' in a sequential burst: the high bits are kept and
  // the low bits wrap inside the aligned block of 'blen' words.
  function automatic logic [15:0] burst_col(input logic [15:0] base,
                                            input logic [15:0] step,
                                            input logic [15:0] blen);
    logic [15:0] wrap;
    wrap = blen - 16'd1;
    return (base & ~wrap) | ((base + step) & wrap);
  endfunction

endpackage

// File: rtl/sbs_sequencer.sv
module sbs_sequencer
  import sbs_pkg::*;
#(
  parameter int TRCD      = 2,
  parameter int BURST_LEN = 4,
  localparam int IDX_W    = $clog2(BURST_LEN) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             grant,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             rd_last,
  output logic             req_ready,
  output logic             busy,
  output logic             issue_act,
  output logic             issue_rw,
  output logic             rw_is_write,
  output logic             wr_take,
  output logic [IDX_W-1:0] wr_idx
);

  localparam int CNT_W = $clog2(TRCD + 1);
  localparam logic [IDX_W-1:0] LAST_BEAT = IDX_W'(BURST_LEN - 1);

  seq_st_e          state;
  logic [CNT_W-1:0] gap_cnt;
  logic [IDX_W-1:0] beat;
  logic             wr_q;
  logic             accept;

  assign req_ready   = grant && (state == ST_IDLE);
  assign accept      = req_valid && req_ready;
  assign issue_act   = accept;
  assign issue_rw    = (state == ST_GAP) && (gap_cnt == '0);
  assign rw_is_write = wr_q;
  assign busy        = (state != ST_IDLE);
  assign wr_take     = (issue_rw && wr_q) ||
                       ((state == ST_WBURST) && (beat != LAST_BEAT));
  assign wr_idx      = (state == ST_WBURST) ? beat + IDX_W'(1) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      gap_cnt <= '0;
      beat    <= '0;
      wr_q    <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (accept) begin
            state   <= ST_GAP;
            gap_cnt <= CNT_W'(TRCD - 1);
            wr_q    <= req_write;
          end
        end
        ST_GAP: begin
          if (gap_cnt == '0) begin
            state <= wr_q ? ST_WBURST : ST_RWAIT;
            beat  <= '0;
          end else begin
            gap_cnt <= gap_cnt - CNT_W'(1);
          end
        end
        ST_WBURST: begin
          if (beat == LAST_BEAT) state <= ST_IDLE;
          else                   beat  <= beat + IDX_W'(1);
        end
        ST_RWAIT: begin
          if (rd_last) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sbs_write_path.sv
module sbs_write_path #(
  parameter int DATA_W = 16,
  localparam int MASK_W = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_take,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [MASK_W-1:0] wr_mask,
  output logic              dq_oe,
  output logic [DATA_W-1:0] dq_out,
  output logic [MASK_W-1:0] dqm
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dq_oe  <= 1'b0;
      dq_out <= '0;
      dqm    <= '0;
    end else begin
      dq_oe <= wr_take;
      dqm   <= wr_take ? wr_mask : '0;
      if (wr_take) dq_out <= wr_data;
    end
  end

endmodule

// File: rtl/sbs_read_capture.sv
module sbs_read_capture
  import sbs_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int COL_W     = 9,
  parameter int CAS_LAT   = 3,
  parameter int BURST_LEN = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_start,
  input  logic [COL_W-1:0]  base_col,
  input  logic [DATA_W-1:0] dq_in,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [COL_W-1:0]  rd_col,
  output logic              rd_last
);

  localparam int CAP_W = $clog2(BURST_LEN + 1);

  logic [CAS_LAT-1:0] lat_sr;
  logic [CAP_W-1:0]   cap_cnt;
  logic               window_open;

  // One bit per cycle since the READ command; the top bit opens the window.
  generate
    if (CAS_LAT > 1) begin : g_deep
      always_ff @(posedge clk) begin
        if (!rst_n) lat_sr <= '0;
        else        lat_sr <= {lat_sr[CAS_LAT-2:0], rd_start};
      end
    end else begin : g_single
      always_ff @(posedge clk) begin
        if (!rst_n) lat_sr <= '0;
        else        lat_sr <= rd_start;
      end
    end
  endgenerate

  assign window_open = (cap_cnt != '0);
  assign rd_last     = (cap_cnt == CAP_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_cnt  <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
      rd_col   <= '0;
    end else begin
      if (lat_sr[CAS_LAT-1])  cap_cnt <= CAP_W'(BURST_LEN);
      else if (window_open)   cap_cnt <= cap_cnt - CAP_W'(1);
      rd_valid <= window_open;
      if (window_open) begin
        rd_data <= dq_in;
        rd_col  <= COL_W'(burst_col(16'(base_col),
                                    16'(BURST_LEN) - 16'(cap_cnt),
                                    16'(BURST_LEN)));
      end
    end
  end

endmodule

// File: rtl/sdram_burst_seq.sv
module sdram_burst_seq
  import sbs_pkg::*;
#(
  parameter int BANK_W    = 2,
  parameter int ROW_W     = 12,
  parameter int COL_W     = 9,
  parameter int DATA_W    = 16,
  parameter int BURST_LEN = 4,
  parameter int CAS_LAT   = 3,
  parameter int TRCD      = 2,
  parameter int AP_BIT    = 10,
  localparam int MASK_W   = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              grant,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  output logic              wr_take,
  output logic [COL_W-1:0]  wr_col,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [MASK_W-1:0] wr_mask,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [COL_W-1:0]  rd_col,
  output logic              busy,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [BANK_W-1:0] sd_ba,
  output logic [ROW_W-1:0]  sd_addr,
  output logic [MASK_W-1:0] sd_dqm,
  output logic              dq_oe,
  output logic [DATA_W-1:0] dq_out,
  input  logic [DATA_W-1:0] dq_in
);

  localparam int IDX_W = $clog2(BURST_LEN) + 1;

  // Named internal events
  logic             issue_act;
  logic             issue_rw;
  logic             rw_is_write;
  logic             rd_start;
  logic             rd_last;
  logic [IDX_W-1:0] wr_idx;

  sd_cmd_e           cmd_q;
  logic [BANK_W-1:0] ba_q;
  logic [ROW_W-1:0]  addr_q;
  logic [BANK_W-1:0] bank_q;
  logic [COL_W-1:0]  col_q;
  logic [ROW_W-1:0]  rw_addr;

  sbs_sequencer #(.TRCD(TRCD), .BURST_LEN(BURST_LEN)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .grant      (grant),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .rd_last    (rd_last),
    .req_ready  (req_ready),
    .busy       (busy),
    .issue_act  (issue_act),
    .issue_rw   (issue_rw),
    .rw_is_write(rw_is_write),
    .wr_take    (wr_take),
    .wr_idx     (wr_idx)
  );

  assign rd_start = issue_rw && !rw_is_write;

  // Column command address: column in the low bits, precharge bit held low.
  always_comb begin
    rw_addr                = '0;
    rw_addr[COL_W-1:0]     = col_q;
    rw_addr[AP_BIT]        = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q  <= CMD_NOP;
      ba_q   <= '0;
      addr_q <= '0;
      bank_q <= '0;
      col_q  <= '0;
    end else if (issue_act) begin
      cmd_q  <= CMD_ACT;
      ba_q   <= req_bank;
      addr_q <= req_row;
      bank_q <= req_bank;
      col_q  <= req_col;
    end else if (issue_rw) begin
      cmd_q  <= rw_is_write ? CMD_WR : CMD_RD;
      ba_q   <= bank_q;
      addr_q <= rw_addr;
    end else begin
      cmd_q  <= CMD_NOP;
    end
  end

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_q;
  assign sd_ba   = ba_q;
  assign sd_addr = addr_q;
  assign wr_col  = COL_W'(burst_col(16'(col_q), 16'(wr_idx), 16'(BURST_LEN)));

  sbs_write_path #(.DATA_W(DATA_W)) u_wr (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_take(wr_take),
    .wr_data(wr_data),
    .wr_mask(wr_mask),
    .dq_oe  (dq_oe),
    .dq_out (dq_out),
    .dqm    (sd_dqm)
  );

  sbs_read_capture #(
    .DATA_W(DATA_W), .COL_W(COL_W), .CAS_LAT(CAS_LAT), .BURST_LEN(BURST_LEN)
  ) u_rd (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_start(rd_start),
    .base_col(col_q),
    .dq_in   (dq_in),
    .rd_valid(rd_valid),
    .rd_data (rd_data),
    .rd_col  (rd_col),
    .rd_last (rd_last)
  );

endmodule

// File: rtl/sbs_checker.sv
module sbs_checker #(
  parameter int BANK_W = 2,
  parameter int ROW_W  = 12,
  parameter int DATA_W = 16,
  parameter int TRCD   = 2,
  parameter int AP_BIT = 10,
  localparam int MASK_W = DATA_W / 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              grant,
  input logic              req_valid,
  input logic              req_ready,
  input logic              busy,
  input logic              sd_cs_n,
  input logic              sd_ras_n,
  input logic              sd_cas_n,
  input logic              sd_we_n,
  input logic [ROW_W-1:0]  sd_addr,
  input logic [MASK_W-1:0] sd_dqm,
  input logic              dq_oe,
  input logic [DATA_W-1:0] dq_in,
  input logic              rd_valid,
  input logic [DATA_W-1:0] rd_data
);

  logic [3:0] pins;
  logic       act_now;
  logic       col_cmd_now;
  logic [7:0] since_act;

  assign pins        = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
  assign act_now     = (pins == 4'b0011);
  assign col_cmd_now = (pins == 4'b0101) || (pins == 4'b0100);

  always_ff @(posedge clk) begin
    if (!rst_n)                                   since_act <= '0;
    else if (act_now)                             since_act <= 8'd1;
    else if (since_act != '0 && since_act != '1)  since_act <= since_act + 8'd1;
  end

  assert_ready_needs_grant_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> grant);

  assert_act_follows_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    act_now |-> $past(req_valid && req_ready));

  assert_col_cmd_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
    col_cmd_now |-> since_act == 8'(TRCD));

  assert_col_cmd_no_autopre_R3: assert property (@(posedge clk) disable iff (!rst_n)
    col_cmd_now |-> !sd_addr[AP_BIT]);

  assert_oe_inside_access_R4: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> busy);

  assert_mask_only_with_oe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !dq_oe |-> sd_dqm == '0);

  assert_capture_matches_bus_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> rd_data == $past(dq_in));

  assert_busy_at_act_R8: assert property (@(posedge clk) disable iff (!rst_n)
    act_now |-> busy);

  assert_never_precharge_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pins != 4'b0010);

endmodule

bind sdram_burst_seq sbs_checker #(
  .BANK_W(BANK_W), .ROW_W(ROW_W), .DATA_W(DATA_W), .TRCD(TRCD), .AP_BIT(AP_BIT)
) u_sbs_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .grant    (grant),
  .req_valid(req_valid),
  .req_ready(req_ready),
  .busy     (busy),
  .sd_cs_n  (sd_cs_n),
  .sd_ras_n (sd_ras_n),
  .sd_cas_n (sd_cas_n),
  .sd_we_n  (sd_we_n),
  .sd_addr  (sd_addr),
  .sd_dqm   (sd_dqm),
  .dq_oe    (dq_oe),
  .dq_in    (dq_in),
  .rd_valid (rd_valid),
  .rd_data  (rd_data)
);

// File: tb/tb_sdram_burst_seq.sv
`timescale 1ns/1ps
module tb_sdram_burst_seq;

  localparam int BL   = 4;
  localparam int CL   = 3;
  localparam int TRCD = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        grant = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [1:0]  req_bank = '0;
  logic [11:0] req_row = '0;
  logic [8:0]  req_col = '0;
  logic [15:0] wr_data = '0;
  logic [1:0]  wr_mask = '0;
  logic [15:0] dq_in = '0;
  logic        req_ready, wr_take, rd_valid, busy;
  logic [8:0]  wr_col, rd_col;
  logic [15:0] rd_data, dq_out;
  logic        sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, dq_oe;
  logic [1:0]  sd_ba, sd_dqm;
  logic [11:0] sd_addr;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sdram_burst_seq #(
    .BURST_LEN(BL), .CAS_LAT(CL), .TRCD(TRCD)
  ) dut (
    .clk(clk), .rst_n(rst_n), .grant(grant), .req_valid(req_valid),
    .req_ready(req_ready), .req_write(req_write), .req_bank(req_bank),
    .req_row(req_row), .req_col(req_col), .wr_take(wr_take), .wr_col(wr_col),
    .wr_data(wr_data), .wr_mask(wr_mask), .rd_valid(rd_valid),
    .rd_data(rd_data), .rd_col(rd_col), .busy(busy), .sd_cs_n(sd_cs_n),
    .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
    .sd_ba(sd_ba), .sd_addr(sd_addr), .sd_dqm(sd_dqm), .dq_oe(dq_oe),
    .dq_out(dq_out), .dq_in(dq_in)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  function automatic logic [15:0] wpat(input int seed, input int k);
    return 16'(seed * 4951 + k * 3855 + 9320);
  endfunction
  function automatic logic [1:0] wmsk(input int seed, input int k);
    return 2'((seed + k) % 4);
  endfunction
  function automatic logic [15:0] rpat(input int seed, input int k);
    return 16'(seed * 7919 + k * 257 + 40961);
  endfunction
  function automatic logic [8:0] exp_col(input logic [8:0] base, input int k);
    int b;
    b = int'(base);
    return 9'((b / BL) * BL + ((b % BL) + k) % BL);
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic run_op(input bit wr, input logic [1:0] bk, input logic [11:0] row,
                        input logic [8:0] col, input int seed);
    int last;
    int wk;
    last = wr ? TRCD + BL : TRCD + CL + BL;
    wk = 0;
    chk("R1", "ready before request", {31'd0, req_ready}, 32'd1);
    req_valid = 1'b1; req_write = wr; req_bank = bk; req_row = row; req_col = col;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    req_row = ~row;
    req_col = ~col;
    req_bank = ~bk;
    for (int n = 0; n <= last + 3; n++) begin
      logic [3:0] exp_cmd;
      logic [3:0] pins;
      bool_t:
      begin end
      pins = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
      exp_cmd = (n == 0) ? 4'b0011 : (n == TRCD) ? (wr ? 4'b0100 : 4'b0101) : 4'b0111;
      if (n == 0) begin
        chk("R2", "ACTIVE pins", {28'd0, pins}, {28'd0, exp_cmd});
        chk("R2", "ACTIVE bank", {30'd0, sd_ba}, {30'd0, bk});
        chk("R2", "ACTIVE row", {20'd0, sd_addr}, {20'd0, row});
      end else if (n == TRCD) begin
        chk("R3", "column command pins", {28'd0, pins}, {28'd0, exp_cmd});
        chk("R3", "column command bank", {30'd0, sd_ba}, {30'd0, bk});
        chk("R3", "column command addr", {20'd0, sd_addr}, {23'd0, col});
      end else begin
        chk("R9", "idle command pins", {28'd0, pins}, {28'd0, exp_cmd});
      end
      chk("R8", "busy", {31'd0, busy}, {31'd0, (n < last)});
      chk("R1", "ready", {31'd0, req_ready}, {31'd0, (n >= last)});
      if (wr) begin
        bit in_data;
        bit take_exp;
        in_data  = (n >= TRCD) && (n <= TRCD + BL - 1);
        take_exp = (n >= TRCD - 1) && (n <= TRCD + BL - 2);
        chk("R4", "dq_oe", {31'd0, dq_oe}, {31'd0, in_data});
        if (in_data) begin
          chk("R4", "dq_out word", {16'd0, dq_out}, {16'd0, wpat(seed, n - TRCD)});
          chk("R5", "dqm word", {30'd0, sd_dqm}, {30'd0, wmsk(seed, n - TRCD)});
        end else begin
          chk("R5", "dqm idle", {30'd0, sd_dqm}, 32'd0);
        end
        chk("R4", "wr_take", {31'd0, wr_take}, {31'd0, take_exp});
        if (take_exp) begin
          chk("R7", "wr_col", {23'd0, wr_col}, {23'd0, exp_col(col, wk)});
          wr_data = wpat(seed, wk);
          wr_mask = wmsk(seed, wk);
          wk++;
        end else begin
          wr_data = 16'hFFFF;
          wr_mask = 2'b11;
        end
      end else begin
        bit vexp;
        vexp = (n >= TRCD + CL + 1) && (n <= TRCD + CL + BL);
        chk("R4", "dq_oe low on read", {31'd0, dq_oe}, 32'd0);
        chk("R6", "rd_valid", {31'd0, rd_valid}, {31'd0, vexp});
        if (vexp) begin
          chk("R6", "rd_data", {16'd0, rd_data}, {16'd0, rpat(seed, n - TRCD - CL - 1)});
          chk("R7", "rd_col", {23'd0, rd_col}, {23'd0, exp_col(col, n - TRCD - CL - 1)});
        end
        if ((n >= TRCD + CL) && (n <= TRCD + CL + BL - 1)) dq_in = rpat(seed, n - TRCD - CL);
        else dq_in = 16'(16'hA5A5 ^ n);
      end
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R2", "reset pins NOP", {28'd0, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, 32'h7);
    chk("R8", "reset busy", {31'd0, busy}, 32'd0);
    chk("R4", "reset dq_oe", {31'd0, dq_oe}, 32'd0);
    chk("R6", "reset rd_valid", {31'd0, rd_valid}, 32'd0);
    chk("R5", "reset dqm", {30'd0, sd_dqm}, 32'd0);

    // R1: no grant, request ignored
    grant = 1'b0;
    req_valid = 1'b1; req_write = 1'b1; req_bank = 2'd1; req_row = 12'h123; req_col = 9'h010;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      chk("R1", "ready without grant", {31'd0, req_ready}, 32'd0);
      chk("R1", "busy without grant", {31'd0, busy}, 32'd0);
      chk("R1", "pins without grant", {28'd0, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, 32'h7);
    end
    req_valid = 1'b0;
    grant = 1'b1;
    @(negedge clk);

    // Sweep both directions over every in-burst alignment and the column edges
    for (int d = 0; d < 2; d++) begin
      for (int c = 0; c < 20; c++) begin
        logic [8:0] col;
        col = (c < 16) ? 9'(c) : 9'(508 + (c - 16));
        run_op(d == 0, 2'(c % 4), 12'(c * 211 + d * 2048 + 1), col, c + 40 * d);
      end
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule